// File: doc/BRIEF.md
# Speculative Stack Offset Tracker

This unit sits between instruction decode and a simple back-end model. It tracks stack-pointer changes from push and pop instructions in a narrow signed offset held in the front end. No separate arithmetic micro-op is issued for those changes. Each stack memory micro-op leaves the front end tagged with the offset in force when it is dispatched. The back-end model adds that offset to its architectural stack base to form the address.

The base is brought up to date only when needed. That happens when the offset would leave its signed range, when an instruction outside the push/pop family reads or writes the stack pointer, or when the mechanism is switched off. In each case a synchronization micro-op is injected ahead of the instruction. It folds the offset into the base and clears the offset.

Two configuration pins control the mechanism. One turns it off, so every push or pop produces an explicit pointer-adjust micro-op. The other holds the front end after each synchronization until the back end acknowledges the base update. A flush clears the offset and drops any wait for an acknowledgement.

Instructions enter on a valid/ready stream. Micro-op results leave on a second valid/ready stream. A result held under back-pressure keeps all its fields, and back-pressure propagates through a single register stage to the instruction input.

Top module: `stack_delta_tracker`

## Requirements
- R1: With the mechanism enabled, a push (in_op=1) yields exactly one micro-op, kind 1. Its out_addr equals the stack pointer after it is lowered by SLOT (8).
- R2: With the mechanism enabled, a pop (in_op=2) yields exactly one micro-op, kind 2. Its out_addr equals the stack pointer before the pop, and the pointer then rises by SLOT.
- R3: The offset is a signed DELTA_W-bit value (default range -512..511). A push or pop that would take it outside that range is preceded by one synchronization micro-op (kind 4) whose out_addr is the updated base, and the offset restarts from zero. No synchronization is emitted while the offset stays in range.
- R4: An instruction that touches the stack pointer (in_op=3) is preceded by a synchronization micro-op when the offset is nonzero. It is then emitted as kind 3 with out_addr equal to the architectural stack pointer.
- R5: With cfg_disable high, a push yields an adjust micro-op (kind 5, out_addr = lowered pointer) followed by a kind 1 store at that pointer. A pop yields a kind 2 load at the current pointer followed by a kind 5 adjust to the raised pointer. The offset stays zero. If it was nonzero when the mode was entered, a synchronization comes first.
- R6: With cfg_serialize high, no instruction is accepted in the cycle after a synchronization is handed to the back end. Acceptance resumes once the acknowledgement returns, so an overflowing pop takes three cycles instead of two.
- R7: out_gen counts base updates (kinds 4 and 5) modulo 2^GEN_W from 0. Every micro-op reports the generation of the base it used, so an old offset is never paired with a new base.
- R8: A flush clears the offset without updating the base. Later stack micro-ops are addressed relative to the architectural base alone.
- R9: While out_valid is high and out_ready low, out_valid, out_kind, out_addr and out_gen hold. Micro-ops leave in issue order, none lost or duplicated.
- R10: After reset, out_valid is low, in_ready is high, the base equals SP_RESET, and the generation and offset are zero.
- R11: An instruction that does not use the stack (in_op=0) yields one kind 0 micro-op whose out_addr is the current speculative stack pointer. It never triggers a synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush: clears offset and pending wait |
| cfg_disable | input | 1 | Turns the offset mechanism off |
| cfg_serialize | input | 1 | Holds the front end until each synchronization is acknowledged |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_op | input | 2 | 0 plain, 1 push, 2 pop, 3 other stack-pointer user |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_kind | output | 3 | 0 plain, 1 push store, 2 pop load, 3 pointer user, 4 sync, 5 adjust |
| out_addr | output | ADDR_W | Formed address, or the new base for kinds 4 and 5 |
| out_gen | output | GEN_W | Base generation used by this micro-op |

## Verification
The bench sweeps pushes and pops across both ends of the offset range in every combination of the two configuration pins. A design with an off-by-one range test would either emit a synchronization one step early or wrap and produce addresses 1024 bytes off. Switching the mode off while the offset is nonzero shows whether the pending offset is folded in first; a design that skips this step loses it permanently. A timed pop at the overflow edge tells a serializing design apart from one that ignores the acknowledgement, and a flush mid-sequence shows whether a stale offset survives into later addresses. Back-pressure on the result stream exposes results that are dropped, duplicated, or change while held.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_SPUSE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    U_PLAIN = 3'd0,
    U_PUSH  = 3'd1,
    U_POP   = 3'd2,
    U_SPUSE = 3'd3,
    U_SYNC  = 3'd4,
    U_ADJ   = 3'd5
  } uop_e;
endpackage

// File: rtl/stk_fe.sv
module stk_fe
  import stk_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int GEN_W   = 4,
  parameter int SLOT    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      cfg_disable,
  input  logic                      cfg_serialize,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_op,
  input  logic                      sync_ack,
  output logic                      u_valid,
  input  logic                      u_ready,
  output logic [2:0]                u_kind,
  output logic signed [DELTA_W-1:0] u_delta,
  output logic [GEN_W-1:0]          u_gen
);
  localparam int DMAX_I = (2 ** (DELTA_W - 1)) - 1;
  localparam int DMIN_I = -(2 ** (DELTA_W - 1));
  localparam logic signed [DELTA_W:0]   HI     = DMAX_I[DELTA_W:0];
  localparam logic signed [DELTA_W:0]   LO     = DMIN_I[DELTA_W:0];
  localparam logic signed [DELTA_W:0]   STEP   = SLOT[DELTA_W:0];
  localparam logic signed [DELTA_W-1:0] STEP_P = SLOT[DELTA_W-1:0];
  localparam logic signed [DELTA_W-1:0] STEP_N = -STEP_P;

  logic signed [DELTA_W-1:0] delta_q;
  logic                      phase_q;
  logic                      wait_q;
  logic [GEN_W-1:0]          gen_q;

  logic signed [DELTA_W:0] ext, nxt_push, nxt_pop;
  logic need_sync, consume, fire;
  op_e  op;

  assign op       = op_e'(in_op);
  assign ext      = {delta_q[DELTA_W-1], delta_q};
  assign nxt_push = ext - STEP;
  assign nxt_pop  = ext + STEP;

  always_comb begin
    need_sync = 1'b0;
    if (delta_q != '0) begin
      unique case (op)
        OP_SPUSE: need_sync = 1'b1;
        OP_PUSH:  need_sync = cfg_disable || (nxt_push < LO);
        OP_POP:   need_sync = cfg_disable || (nxt_pop > HI);
        default:  need_sync = 1'b0;
      endcase
    end
  end

  always_comb begin
    u_kind  = U_PLAIN;
    u_delta = delta_q;
    consume = 1'b0;
    if (need_sync) begin
      u_kind = U_SYNC;
    end else begin
      unique case (op)
        OP_PLAIN: consume = 1'b1;
        OP_SPUSE: begin
          u_kind  = U_SPUSE;
          u_delta = '0;
          consume = 1'b1;
        end
        OP_PUSH: begin
          if (cfg_disable && !phase_q) begin
            u_kind  = U_ADJ;
            u_delta = STEP_N;
          end else begin
            u_kind  = U_PUSH;
            u_delta = cfg_disable ? '0 : nxt_push[DELTA_W-1:0];
            consume = 1'b1;
          end
        end
        default: begin
          if (cfg_disable && phase_q) begin
            u_kind  = U_ADJ;
            u_delta = STEP_P;
            consume = 1'b1;
          end else begin
            u_kind  = U_POP;
            u_delta = cfg_disable ? '0 : delta_q;
            consume = !cfg_disable;
          end
        end
      endcase
    end
  end

  assign u_valid  = in_valid && !wait_q && !flush;
  assign in_ready = !wait_q && !flush && consume && u_ready;
  assign u_gen    = gen_q;
  assign fire     = u_valid && u_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delta_q <= '0;
      phase_q <= 1'b0;
      wait_q  <= 1'b0;
      gen_q   <= '0;
    end else if (flush) begin
      delta_q <= '0;
      phase_q <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      if (sync_ack) wait_q <= 1'b0;
      if (fire) begin
        unique case (uop_e'(u_kind))
          U_SYNC: begin
            delta_q <= '0;
            gen_q   <= gen_q + 1'b1;
            if (cfg_serialize) wait_q <= 1'b1;
          end
          U_ADJ: begin
            gen_q   <= gen_q + 1'b1;
            phase_q <= !phase_q;
          end
          U_PUSH: begin
            if (cfg_disable) phase_q <= 1'b0;
            else delta_q <= nxt_push[DELTA_W-1:0];
          end
          U_POP: begin
            if (cfg_disable) phase_q <= 1'b1;
            else delta_q <= nxt_pop[DELTA_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  AST_SYNC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && u_kind == U_SYNC |=> delta_q == '0); // R3
  AST_OFF_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable && delta_q == '0 |=> delta_q == '0); // R5
  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && u_kind == U_SYNC && cfg_serialize && !flush |=> !in_ready); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> delta_q == '0); // R8
endmodule

// File: rtl/stk_be.sv
module stk_be
  import stk_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DELTA_W  = 10,
  parameter int          GEN_W    = 4,
  parameter logic [ADDR_W-1:0] SP_RESET = 32'h0001_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      u_valid,
  output logic                      u_ready,
  input  logic [2:0]                u_kind,
  input  logic signed [DELTA_W-1:0] u_delta,
  input  logic [GEN_W-1:0]          u_gen,
  output logic                      sync_ack,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [2:0]                out_kind,
  output logic [ADDR_W-1:0]         out_addr,
  output logic [GEN_W-1:0]          out_gen
);
  localparam int PAD = ADDR_W - DELTA_W;

  logic [ADDR_W-1:0] base_q, sum;
  logic [GEN_W-1:0]  gen_q;
  logic              acc, is_upd;

  assign u_ready = !out_valid || out_ready;
  assign acc     = u_valid && u_ready;
  assign sum     = base_q + {{PAD{u_delta[DELTA_W-1]}}, u_delta};
  assign is_upd  = (u_kind == U_SYNC) || (u_kind == U_ADJ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= SP_RESET;
      gen_q     <= '0;
      sync_ack  <= 1'b0;
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_gen   <= '0;
    end else begin
      sync_ack <= acc && (u_kind == U_SYNC);
      if (acc) begin
        out_valid <= 1'b1;
        out_kind  <= u_kind;
        out_addr  <= sum;
        out_gen   <= is_upd ? gen_q + 1'b1 : gen_q;
        if (is_upd) begin
          base_q <= sum;
          gen_q  <= gen_q + 1'b1;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_GEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> u_gen == gen_q); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_kind) && $stable(out_gen)); // R9
endmodule

// File: rtl/stack_delta_tracker.sv
module stack_delta_tracker #(
  parameter int          ADDR_W   = 32,
  parameter int          DELTA_W  = 10,
  parameter int          GEN_W    = 4,
  parameter int          SLOT     = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cfg_disable,
  input  logic              cfg_serialize,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [GEN_W-1:0]  out_gen
);
  logic                      u_valid, u_ready, sync_ack;
  logic [2:0]                u_kind;
  logic signed [DELTA_W-1:0] u_delta;
  logic [GEN_W-1:0]          u_gen;

  stk_fe #(.DELTA_W(DELTA_W), .GEN_W(GEN_W), .SLOT(SLOT)) u_fe (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cfg_disable(cfg_disable), .cfg_serialize(cfg_serialize),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .sync_ack(sync_ack),
    .u_valid(u_valid), .u_ready(u_ready), .u_kind(u_kind),
    .u_delta(u_delta), .u_gen(u_gen)
  );

  stk_be #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .GEN_W(GEN_W), .SP_RESET(SP_RESET)) u_be (
    .clk(clk), .rst_n(rst_n),
    .u_valid(u_valid), .u_ready(u_ready), .u_kind(u_kind),
    .u_delta(u_delta), .u_gen(u_gen), .sync_ack(sync_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_gen(out_gen)
  );
endmodule

// File: tb/stack_delta_tracker_bench.sv
module stack_delta_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int HI = (2 ** (DW - 1)) - 1;
  localparam int LO = -(2 ** (DW - 1));
  localparam logic [31:0] SP0 = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, cfg_disable = 1'b0, cfg_serialize = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [1:0] in_op = '0;
  logic [2:0] out_kind;
  logic [31:0] out_addr;
  logic [3:0] out_gen;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_delta_tracker u_stack_delta_tracker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_disable(cfg_disable),
    .cfg_serialize(cfg_serialize), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_addr(out_addr), .out_gen(out_gen)
  );

  int n_chk = 0, n_bad = 0;
  logic [2:0]  qk[256];
  logic [31:0] qa[256];
  logic [3:0]  qg[256];
  string       qt_tag[256];
  int qh = 0, qt = 0;
  logic [31:0] ref_base = SP0;
  int          ref_d = 0;
  logic [3:0]  ref_gen = '0;
  string       tag_ovr = "";
  bit          bp_en = 1'b0;
  int          cyc_cnt = 0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R4";
      3'd4: return "R3";
      3'd5: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic enq(input logic [2:0] k, input logic [31:0] a);
    qk[qt[7:0]] = k; qa[qt[7:0]] = a; qg[qt[7:0]] = ref_gen;
    qt_tag[qt[7:0]] = (tag_ovr != "") ? tag_ovr : kind_tag(k);
    qt++;
  endtask

  task automatic predict(input logic [1:0] op);
    bit sy;
    sy = (ref_d != 0) && ((op == 2'd3) ||
         (op == 2'd1 && (cfg_disable || ref_d - 8 < LO)) ||
         (op == 2'd2 && (cfg_disable || ref_d + 8 > HI)));
    if (sy) begin
      ref_base = ref_base + 32'(ref_d); ref_d = 0; ref_gen++;
      enq(3'd4, ref_base);
    end
    case (op)
      2'd0: enq(3'd0, ref_base + 32'(ref_d));
      2'd3: enq(3'd3, ref_base);
      2'd1: if (cfg_disable) begin
              ref_base -= 8; ref_gen++; enq(3'd5, ref_base); enq(3'd1, ref_base);
            end else begin
              ref_d -= 8; enq(3'd1, ref_base + 32'(ref_d));
            end
      default: if (cfg_disable) begin
              enq(3'd2, ref_base); ref_base += 8; ref_gen++; enq(3'd5, ref_base);
            end else begin
              enq(3'd2, ref_base + 32'(ref_d)); ref_d += 8;
            end
    endcase
  endtask

  task automatic send(input logic [1:0] op, output int cyc);
    predict(op);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; cyc = 0;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1; cyc++;
    end
    @(posedge clk);
    cyc++;
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (qh != qt || out_valid) @(negedge clk);
  endtask

  // back-pressure pattern, changed away from the sampling edge
  always @(posedge clk) begin
    cyc_cnt++;
    #2 out_ready = bp_en ? ((cyc_cnt % 5) != 2 && (cyc_cnt % 7) != 3) : 1'b1;
  end

  // result monitor
  logic        pv = 1'b0, pr = 1'b1;
  logic [31:0] pa = '0;
  logic [2:0]  pk = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(out_valid && out_addr == pa && out_kind == pk, "R9 hold", {out_valid, out_addr}, {1'b1, pa});
      if (out_valid && out_ready) begin
        if (qh == qt) chk(1'b0, "R9 extra result", out_addr, 0);
        else begin
          chk(out_kind == qk[qh[7:0]], qt_tag[qh[7:0]], out_kind, qk[qh[7:0]]);
          chk(out_addr == qa[qh[7:0]], qt_tag[qh[7:0]], out_addr, qa[qh[7:0]]);
          chk(out_gen == qg[qh[7:0]], "R7", out_gen, qg[qh[7:0]]);
          qh++;
        end
      end
      pv = out_valid; pr = out_ready; pa = out_addr; pk = out_kind;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    tag_ovr = "R10";
    send(2'd0, c);
    tag_ovr = "";
    lf = 16'hACE1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      @(negedge clk);
      cfg_disable = cfg[1]; cfg_serialize = cfg[0];
      bp_en = 1'b1;
      for (int i = 0; i < 70; i++) send(2'd1, c);
      send(2'd0, c);
      for (int i = 0; i < 150; i++) send(2'd2, c);
      send(2'd3, c);
      for (int i = 0; i < 120; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        send(lf[1:0], c);
      end
      for (int i = 0; i < 3; i++) send(2'd1, c);
      drain();
      // R8: flush discards the speculative offset
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      ref_d = 0;
      tag_ovr = "R8";
      send(2'd2, c);
      send(2'd1, c);
      tag_ovr = "";
      if (cfg == 1) for (int i = 0; i < 5; i++) send(2'd1, c);
    end
    // R6: timing of an overflowing pop with and without serialization
    bp_en = 1'b0;
    @(negedge clk); cfg_disable = 1'b0;
    for (int s = 0; s < 2; s++) begin
      drain();
      @(negedge clk); cfg_serialize = s[0]; flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      ref_d = 0;
      for (int i = 0; i < 63; i++) send(2'd2, c);
      drain();
      send(2'd2, c);
      chk(c == (s == 1 ? 3 : 2), "R6 cycles", c, s == 1 ? 3 : 2);
    end
    drain();
    repeat (4) @(negedge clk);
    chk(qh == qt, "R9 results outstanding", qt - qh, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule